// File: doc/BRIEF.md
# Walking Address-Line Test Engine

This block is a self-contained sequencer that looks for broken address wiring between a controller and a word-wide memory. A stuck or shorted address line makes two different byte addresses reach the same storage cell, so writing one of them silently alters the other. The engine picks a test address and, one address bit at a time, forms a partner address that differs from it in exactly that bit. It then writes to the test address and watches whether the partner moved with it.

The walk begins at the lowest bit above the byte-within-word bits and moves up until the flipped bit leaves the address width. Partners outside the region under test are skipped. A run covers the region twice: once from its lowest address, so a single one walks through zeros, and once from the word eight bytes below its end, so a single zero walks through ones. The engine talks to memory over a request/acknowledge word port and reports completion, a pass flag and, on a failure, the test address, the partner address and the flipped bit. A debug input can force a mismatch at one chosen bit so that the failure path can be exercised on healthy memory.

The controller has seven states. `ST_IDLE` waits for `start` after reset. `ST_SETUP` loads the test address for the current pass and resets the bit mask. `ST_PROBE` decides: it goes back to `ST_SETUP` for the second pass or on to `ST_DONE` once the mask has left the address width, goes to `ST_RD_PRE` when the partner lies inside the region, and otherwise shifts the mask and stays in `ST_PROBE`. `ST_RD_PRE` reads the partner. `ST_WR_INV` writes the inverse of that value to the test address. `ST_RD_POST` reads the partner again. From there it goes to `ST_DONE` on aliasing, or shifts the mask and returns to `ST_PROBE`. `ST_DONE` holds the result until the next `start`, which leads to `ST_SETUP`.

Top module: `addr_line_walker`

## Requirements
- R1: After reset, `done`, `busy` and `mem_req` are all 0.
- R2: Within a pass, the flipped bit mask starts at the word size in bytes (4 for 32-bit data) and doubles after each step. The pass ends once the mask exceeds the top address bit, so partners appear in ascending bit order.
- R3: A partner address below `base_addr` or at or above `base_addr + region_size` produces no memory access. No read ever leaves that range.
- R4: Each tested partner costs exactly three accesses in this order: a read of the partner, a write to the test address whose data is the bitwise inverse of the value just read, and a second read of the partner.
- R5: If the second partner read equals the value written to the test address, the run stops at once. `done` rises with `pass` = 0, and `fail_test_addr`, `fail_partner_addr` and `fail_mask` hold the test address, the partner and the one-hot flipped bit.
- R6: The first pass uses test address `base_addr`. The second pass uses `base_addr + region_size - 8` and runs only if the first pass found no aliasing. Every write goes to one of these two addresses.
- R7: When both passes finish clean, `done` = 1 and `pass` = 1. `done` stays high, with `busy` low and no memory traffic, until the next `start`.
- R8: With `dbg_force_en` = 1, the step whose mask equals `1 << dbg_force_bit` treats its second read as matching, and reports that failure under R5.
- R9: Once `mem_req` is raised, it stays high with address, write flag and write data unchanged until a cycle in which `mem_ack` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted in idle or done) |
| base_addr | input | ADDR_W | Lowest byte address of the region |
| region_size | input | ADDR_W+1 | Region length in bytes |
| dbg_force_en | input | 1 | Enable forced mismatch |
| dbg_force_bit | input | $clog2(ADDR_W) | Address bit at which the mismatch is forced |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | DATA_W | Read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; result valid |
| pass | output | 1 | No aliasing found (valid with done) |
| fail_test_addr | output | ADDR_W | Test address of the failing step |
| fail_partner_addr | output | ADDR_W | Partner address of the failing step |
| fail_mask | output | ADDR_W | One-hot flipped bit of the failing step |

## Verification
Some rules are checked by the assertions on every cycle. These are the request hold rule, that every read stays in the region, that writes only reach the two permitted test addresses, that the mask stays one-hot and above the byte-select bits, that done and busy never overlap, and that a failure report carries a one-hot mask. Other behaviour can only be shown by the bench scenarios, which log each memory transaction. These are the exact access order, the inverse write data, which partners are skipped, the ascending bit order, and whether the second pass runs. The scenarios cover a clean region at address zero, an offset region, an injected aliasing cell, a forced mismatch, and a forced mismatch that only the second pass can reach.

// File: rtl/alw_pkg.sv
package alw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_PROBE   = 3'd2,
        ST_RD_PRE  = 3'd3,
        ST_WR_INV  = 3'd4,
        ST_RD_POST = 3'd5,
        ST_DONE    = 3'd6
    } alw_state_e;

endpackage

// File: rtl/alw_mask_walker.sv
module alw_mask_walker #(
    parameter int ADDR_W     = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] test_addr,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W:0]   limit,
    output logic [ADDR_W:0]   mask,
    output logic [ADDR_W-1:0] partner,
    output logic              in_range
);
    localparam int MASK_W = ADDR_W + 1;
    localparam logic [MASK_W-1:0] INIT_MASK = MASK_W'(WORD_BYTES);
    localparam logic [MASK_W-1:0] LOW_BITS  = MASK_W'(WORD_BYTES - 1);

    logic [MASK_W-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= INIT_MASK;
        end else if (load) begin
            mask_q <= INIT_MASK;
        end else if (advance) begin
            mask_q <= {mask_q[MASK_W-2:0], 1'b0};
        end
    end

    always_comb begin
        mask     = mask_q;
        partner  = test_addr ^ mask_q[ADDR_W-1:0];
        in_range = (partner >= base_addr) && ({1'b0, partner} < limit);
    end

    // R2
    mask_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_q & LOW_BITS) == '0) && ($countones(mask_q) == 1));

endmodule

// File: rtl/alw_alias_judge.sv
module alw_alias_judge #(
    parameter int DATA_W = 32,
    parameter int MASK_W = 17,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] rdata,
    input  logic              force_en,
    input  logic [IDX_W-1:0]  force_bit,
    input  logic [MASK_W-1:0] mask,
    output logic [DATA_W-1:0] wval,
    output logic              hit
);
    logic [DATA_W-1:0] wval_q;
    logic              forced;
    logic [DATA_W-1:0] observed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wval_q <= '0;
        end else if (capture) begin
            wval_q <= ~rdata;
        end
    end

    always_comb begin
        forced   = force_en && (mask == (MASK_W'(1) << force_bit));
        observed = forced ? wval_q : rdata;
        hit      = (observed == wval_q);
        wval     = wval_q;
    end

endmodule

// File: rtl/addr_line_walker.sv
module addr_line_walker
    import alw_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int TAIL_BYTES = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [ADDR_W-1:0]         base_addr,
    input  logic [ADDR_W:0]           region_size,
    input  logic                      dbg_force_en,
    input  logic [$clog2(ADDR_W)-1:0] dbg_force_bit,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [DATA_W-1:0]         mem_wdata,
    input  logic                      mem_ack,
    input  logic [DATA_W-1:0]         mem_rdata,
    output logic                      busy,
    output logic                      done,
    output logic                      pass,
    output logic [ADDR_W-1:0]         fail_test_addr,
    output logic [ADDR_W-1:0]         fail_partner_addr,
    output logic [ADDR_W-1:0]         fail_mask
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int MASK_W     = ADDR_W + 1;
    localparam int IDX_W      = $clog2(ADDR_W);

    alw_state_e state_q, state_d;

    logic [ADDR_W-1:0] base_q, top_q, test_q;
    logic [ADDR_W:0]   limit_q;
    logic [ADDR_W:0]   limit_calc;
    logic              pass_sel_q, pass_q;
    logic [ADDR_W-1:0] fail_test_q, fail_part_q, fail_mask_q;

    logic [MASK_W-1:0] mask_w;
    logic [ADDR_W-1:0] partner_w;
    logic              in_range_w, exhausted_w;
    logic              load_w, advance_w, capture_w;
    logic [DATA_W-1:0] wval_w;
    logic              hit_w;

    assign limit_calc  = {1'b0, base_addr} + region_size;
    assign exhausted_w = mask_w[ADDR_W];

    alw_mask_walker #(
        .ADDR_W    (ADDR_W),
        .WORD_BYTES(WORD_BYTES)
    ) walker_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_w),
        .advance  (advance_w),
        .test_addr(test_q),
        .base_addr(base_q),
        .limit    (limit_q),
        .mask     (mask_w),
        .partner  (partner_w),
        .in_range (in_range_w)
    );

    alw_alias_judge #(
        .DATA_W(DATA_W),
        .MASK_W(MASK_W),
        .IDX_W (IDX_W)
    ) judge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture_w),
        .rdata    (mem_rdata),
        .force_en (dbg_force_en),
        .force_bit(dbg_force_bit),
        .mask     (mask_w),
        .wval     (wval_w),
        .hit      (hit_w)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) state_d = ST_SETUP;
            end
            ST_SETUP: state_d = ST_PROBE;
            ST_PROBE: begin
                if (exhausted_w) begin
                    state_d = pass_sel_q ? ST_DONE : ST_SETUP;
                end else if (in_range_w) begin
                    state_d = ST_RD_PRE;
                end
            end
            ST_RD_PRE: begin
                if (mem_ack) state_d = ST_WR_INV;
            end
            ST_WR_INV: begin
                if (mem_ack) state_d = ST_RD_POST;
            end
            ST_RD_POST: begin
                if (mem_ack) state_d = hit_w ? ST_DONE : ST_PROBE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        mem_req   = (state_q == ST_RD_PRE) || (state_q == ST_WR_INV) ||
                    (state_q == ST_RD_POST);
        mem_we    = (state_q == ST_WR_INV);
        mem_addr  = (state_q == ST_WR_INV) ? test_q : partner_w;
        mem_wdata = wval_w;
        busy      = (state_q != ST_IDLE) && (state_q != ST_DONE);
        done      = (state_q == ST_DONE);
        pass      = done && pass_q;
        load_w    = (state_q == ST_SETUP);
        capture_w = (state_q == ST_RD_PRE) && mem_ack;
        advance_w = ((state_q == ST_PROBE) && !exhausted_w && !in_range_w) ||
                    ((state_q == ST_RD_POST) && mem_ack && !hit_w);
        fail_test_addr    = fail_test_q;
        fail_partner_addr = fail_part_q;
        fail_mask         = fail_mask_q;
    end

    // Run context and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q      <= '0;
            limit_q     <= '0;
            top_q       <= '0;
            test_q      <= '0;
            pass_sel_q  <= 1'b0;
            pass_q      <= 1'b0;
            fail_test_q <= '0;
            fail_part_q <= '0;
            fail_mask_q <= '0;
        end else begin
            if ((state_q == ST_IDLE || state_q == ST_DONE) && start) begin
                base_q      <= base_addr;
                limit_q     <= limit_calc;
                top_q       <= limit_calc[ADDR_W-1:0] - ADDR_W'(TAIL_BYTES);
                pass_sel_q  <= 1'b0;
                pass_q      <= 1'b0;
                fail_test_q <= '0;
                fail_part_q <= '0;
                fail_mask_q <= '0;
            end
            if (state_q == ST_SETUP) begin
                test_q <= pass_sel_q ? top_q : base_q;
            end
            if (state_q == ST_PROBE && exhausted_w) begin
                if (pass_sel_q) pass_q <= 1'b1;
                else            pass_sel_q <= 1'b1;
            end
            if (state_q == ST_RD_POST && mem_ack && hit_w) begin
                fail_test_q <= test_q;
                fail_part_q <= partner_w;
                fail_mask_q <= mask_w[ADDR_W-1:0];
            end
        end
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R3
    read_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> ((mem_addr >= base_q) &&
                                  ({1'b0, mem_addr} < limit_q)));

    // R6
    write_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ((mem_addr == base_q) || (mem_addr == top_q)));

    // R7
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    // R5
    fail_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass) |-> ($countones(fail_mask) == 1));

endmodule

// File: tb/addr_line_walker_tb_top.sv
module addr_line_walker_tb_top;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int IDX_W  = $clog2(ADDR_W);
    localparam int WORDS  = 1 << (ADDR_W - 2);
    localparam int LOG_N  = 512;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [ADDR_W:0]   region_size = '0;
    logic              dbg_force_en = 1'b0;
    logic [IDX_W-1:0]  dbg_force_bit = '0;
    logic              mem_req, mem_we, mem_ack;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic              busy, done, pass;
    logic [ADDR_W-1:0] fail_test_addr, fail_partner_addr, fail_mask;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    addr_line_walker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .region_size(region_size), .dbg_force_en(dbg_force_en),
        .dbg_force_bit(dbg_force_bit), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .pass(pass),
        .fail_test_addr(fail_test_addr), .fail_partner_addr(fail_partner_addr),
        .fail_mask(fail_mask)
    );

    // Memory model: a nonzero fault_mask ties that byte-address bit low (aliasing)
    logic [DATA_W-1:0] mem [WORDS];
    logic [ADDR_W-1:0] fault_mask = '0;

    function automatic int phys(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] m;
        m = a & ~fault_mask;
        return int'(m >> 2);
    endfunction

    initial begin
        for (int i = 0; i < WORDS; i++) mem[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                if (mem_we) mem[phys(mem_addr)] <= mem_wdata;
                mem_rdata <= mem[phys(mem_addr)];
            end
        end
    end

    // Transaction log, sampled on the falling edge
    logic              lg_we   [LOG_N];
    logic [ADDR_W-1:0] lg_addr [LOG_N];
    logic [DATA_W-1:0] lg_wd   [LOG_N];
    logic [DATA_W-1:0] lg_rd   [LOG_N];
    int log_n = 0;

    always @(negedge clk) begin
        if (rst_n && mem_req && mem_ack && log_n < LOG_N) begin
            lg_we[log_n]   <= mem_we;
            lg_addr[log_n] <= mem_addr;
            lg_wd[log_n]   <= mem_wdata;
            lg_rd[log_n]   <= mem_rdata;
            log_n          <= log_n + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Expected step list built from the requirements
    logic [ADDR_W-1:0] ex_test [64];
    logic [ADDR_W-1:0] ex_part [64];
    int  ex_n;
    bit  ex_fail;
    logic [ADDR_W-1:0] ex_fmask;

    task automatic build_exp(input int base, input int size, input int stop_mask);
        int t;
        int p;
        ex_n = 0; ex_fail = 0; ex_fmask = '0;
        for (int ps = 0; ps < 2 && !ex_fail; ps++) begin
            t = (ps == 0) ? base : ((base + size - 8) & 16'hFFFF);
            for (int m = 4; m < (1 << ADDR_W) && !ex_fail; m = m << 1) begin
                p = t ^ m;
                if (p >= base && p < base + size) begin
                    ex_test[ex_n] = ADDR_W'(t);
                    ex_part[ex_n] = ADDR_W'(p);
                    ex_n++;
                    if (m == stop_mask) begin
                        ex_fail = 1; ex_fmask = ADDR_W'(m);
                    end
                end
            end
        end
    endtask

    task automatic run(input int base, input int size, input bit fen,
                       input int fbit, output int first);
        int w;
        @(negedge clk);
        base_addr = ADDR_W'(base); region_size = (ADDR_W+1)'(size);
        dbg_force_en = fen; dbg_force_bit = IDX_W'(fbit);
        first = log_n;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        w = 0;
        while (!done && w < 20000) begin @(negedge clk); w++; end
        chk(done == 1'b1, "R7 run completes", done, 1);
        @(negedge clk);
    endtask

    // Compares the logged trace with the expected steps (R2 R3 R4 R6)
    task automatic chk_trace(input string tag, input int first);
        int bad;
        int k;
        bad = 0;
        chk(log_n - first == 3 * ex_n, {tag, " access count"}, log_n - first, 3 * ex_n);
        for (int s = 0; s < ex_n && (first + 3*s + 2) < log_n; s++) begin
            k = first + 3*s;
            if (lg_we[k] || lg_addr[k] != ex_part[s]) bad++;
            if (!lg_we[k+1] || lg_addr[k+1] != ex_test[s]) bad++;
            if (lg_wd[k+1] != ~lg_rd[k]) bad++;
            if (lg_we[k+2] || lg_addr[k+2] != ex_part[s]) bad++;
        end
        chk(bad == 0, {tag, " order/address/inverse data"}, bad, 0);
    endtask

    task automatic t_reset;
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(mem_req == 1'b0, "R1 mem_req after reset", mem_req, 0);
    endtask

    task automatic t_clean_zero;
        int f;
        build_exp(0, 16'h4000, 0);
        run(0, 16'h4000, 0, 0, f);
        chk_trace("R2 R4 R6 clean region at zero", f);
        chk(pass == 1'b1, "R7 pass on clean region", pass, 1);
        repeat (5) @(negedge clk);
        chk(done && !busy && !mem_req, "R7 done held without traffic", {done, busy, mem_req}, 3'b100);
    endtask

    task automatic t_offset;
        int f;
        build_exp(16'h1000, 16'h2000, 0);
        run(16'h1000, 16'h2000, 0, 0, f);
        chk_trace("R3 offset region skips outside partners", f);
        chk(pass == 1'b1, "R3 pass on offset region", pass, 1);
    endtask

    task automatic t_fault;
        int f;
        fault_mask = 16'h0200;
        build_exp(0, 16'h4000, 16'h0200);
        run(0, 16'h4000, 0, 0, f);
        fault_mask = '0;
        chk_trace("R5 R6 stop at aliasing, no second pass", f);
        chk(pass == 1'b0, "R5 fail flagged", pass, 0);
        chk(fail_test_addr == 16'h0000, "R5 fail test addr", fail_test_addr, 16'h0000);
        chk(fail_partner_addr == 16'h0200, "R5 fail partner addr", fail_partner_addr, 16'h0200);
        chk(fail_mask == 16'h0200, "R5 fail mask", fail_mask, 16'h0200);
    endtask

    task automatic t_force;
        int f;
        build_exp(16'h0800, 16'h1000, 16'h0020);
        run(16'h0800, 16'h1000, 1, 5, f);
        chk_trace("R8 forced mismatch trace", f);
        chk(pass == 1'b0 && fail_mask == 16'h0020, "R8 forced fail mask", fail_mask, 16'h0020);
        chk(fail_partner_addr == 16'h0820, "R8 forced fail partner", fail_partner_addr, 16'h0820);
    endtask

    task automatic t_second_pass;
        int f;
        build_exp(16'h0C00, 16'h1000, 16'h0800);
        run(16'h0C00, 16'h1000, 1, 11, f);
        chk_trace("R6 forced mismatch only on second pass", f);
        chk(fail_test_addr == 16'h1BF8, "R6 second pass test addr", fail_test_addr, 16'h1BF8);
        chk(fail_partner_addr == 16'h13F8, "R6 second pass partner", fail_partner_addr, 16'h13F8);
    endtask

    task automatic t_restart;
        @(negedge clk);
        base_addr = 16'h0000; region_size = 17'h00800; dbg_force_en = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && done == 1'b0, "R7 start clears done", {busy, done}, 2'b10);
        while (!done) @(negedge clk);
        chk(pass == 1'b1, "R7 pass after restart", pass, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_clean_zero();
        t_offset();
        t_fault();
        t_force();
        t_second_pass();
        t_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule